// File: doc/BRIEF.md
# Guarded CPU Power-Mode Register

This block is the processor's power and clock mode register, mapped on a simple bus port. It holds six writable bits: a stop request, a halt request, a halt-depth select, an enable for each of the two oscillators (low speed and high speed), and the system clock source select. Each bit drives its own output directly, so power-management logic downstream sees the mode as soon as a write lands.

Software writes the whole register in one bus write. Before it commits, the block checks the value the write would produce against a set of forbidden combinations. If the value breaks any rule, the write is refused: the register keeps its old contents and a one-cycle error pulse is raised. One rule depends on a debug-mode input. Outside debug, the low-speed oscillator must stay enabled.

Reads are combinational. They return the register contents while the address match is asserted and have no side effects.

Top module: `pmode_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, the register holds 0x04. In that state `lsosc_en_o` is 1 and every other mode output is 0.
- R2: The register bits map to outputs as follows:
  - bit 5 is the stop request (`stop_req_o`);
  - bit 4 is the halt request (`halt_req_o`);
  - bit 3 is the halt depth (`halt_deep_o`; 0 is shallow, 1 is deep);
  - bit 2 is the low-speed oscillator enable (`lsosc_en_o`);
  - bit 1 is the high-speed oscillator enable (`hsosc_en_o`);
  - bit 0 is the clock source (`clk_hs_o`; 1 is high speed, 0 is low speed).
- R3: With `bus_sel` high, `bus_rdata` equals the register value and bits 7:6 always read 0, whatever was written to them. With `bus_sel` low, `bus_rdata` is 0.
- R4: A write takes effect at a rising clock edge only when `bus_sel` and `bus_wr` are both high and the resulting value is allowed. With `bus_sel` low, a write strobe changes nothing.
- R5: A write is refused when its resulting value has halt=0, clock source=1 and high-speed oscillator enable=0.
- R6: A write is refused when its resulting value has clock source=0 and low-speed oscillator enable=0.
- R7: A write is refused when its resulting value has stop=1 and halt=1 at the same time.
- R8: While `dbg_mode` is 0, a write is refused when its resulting value has low-speed oscillator enable=0. While `dbg_mode` is 1, such a write is accepted if no other rule forbids it.
- R9: A refused write leaves all six bits unchanged. `wr_reject` is high for the single clock cycle after the refusing edge, and `wr_reject` is 0 after an accepted write.
- R10: Reading, including repeated reads, does not change the register or the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Address match for this register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, zero when not selected |
| dbg_mode | input | 1 | On-chip debug active; relaxes the low-speed oscillator rule |
| wr_reject | output | 1 | One-cycle pulse after a refused write |
| stop_req_o | output | 1 | Stop mode request |
| halt_req_o | output | 1 | Halt mode request |
| halt_deep_o | output | 1 | Halt depth select, 1 is deep |
| lsosc_en_o | output | 1 | Low-speed oscillator enable |
| hsosc_en_o | output | 1 | High-speed oscillator enable |
| clk_hs_o | output | 1 | Clock source select, 1 is high speed |

## Verification
The write data patterns are chosen so that each one breaks exactly one rule. A refusal can therefore be traced to the high-speed-clock rule, the low-speed-clock rule, the stop-and-halt rule or the debug rule alone. Legal values are also included: ones that only just avoid a rule, such as the high-speed clock with its oscillator off while halting. These show that the guard is not stricter than the rules. The same low-oscillator-off value is written with debug off and with debug on, which separates the debug rule from the others. Writes with reserved bits set, writes without the address match, and back-to-back reads show that the stored value changes only on a selected, legal write.

// File: rtl/pmode_pkg.sv
package pmode_pkg;

   localparam int unsigned MODE_BITS = 6;
   localparam int unsigned NUM_RULES = 4;

   localparam int unsigned RULE_HS_NO_OSC = 0;
   localparam int unsigned RULE_LS_NO_OSC = 1;
   localparam int unsigned RULE_STOP_HALT = 2;
   localparam int unsigned RULE_DBG_LSOSC = 3;

   // Field order MSB to LSB matches the bus layout
   typedef struct packed {
      logic stop;
      logic halt;
      logic halt_deep;
      logic lsosc;
      logic hsosc;
      logic clk_hs;
   } mode_t;

   localparam mode_t MODE_RESET = '{stop: 1'b0, halt: 1'b0, halt_deep: 1'b0,
                                    lsosc: 1'b1, hsosc: 1'b0, clk_hs: 1'b0};

endpackage

// File: rtl/pmode_legal.sv
module pmode_legal
   import pmode_pkg::*;
#(
   parameter bit DBG_RULE_EN = 1'b1
) (
   input  mode_t                 cand,
   input  logic                  dbg_mode,
   output logic [NUM_RULES-1:0]  viol,
   output logic                  ok
);

   // Clock source and its oscillator
   assign viol[RULE_HS_NO_OSC] = !cand.halt && cand.clk_hs && !cand.hsosc;
   assign viol[RULE_LS_NO_OSC] = !cand.clk_hs && !cand.lsosc;

   // Low-power requests are exclusive
   assign viol[RULE_STOP_HALT] = cand.stop && cand.halt;

   generate
      if (DBG_RULE_EN) begin : g_dbg_rule
         assign viol[RULE_DBG_LSOSC] = !dbg_mode && !cand.lsosc;
      end else begin : g_no_dbg_rule
         logic unused_dbg;
         assign unused_dbg = dbg_mode;
         assign viol[RULE_DBG_LSOSC] = 1'b0;
      end
   endgenerate

   assign ok = ~|viol;

endmodule

// File: rtl/pmode_reg.sv
module pmode_reg
   import pmode_pkg::*;
#(
   parameter mode_t RST_MODE = MODE_RESET
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  wr_fire,
   input  logic  wr_ok,
   input  mode_t cand,
   output mode_t q,
   output logic  reject
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q      <= RST_MODE;
         reject <= 1'b0;
      end else begin
         reject <= wr_fire && !wr_ok;
         if (wr_fire && wr_ok) begin
            q <= cand;
         end
      end
   end

endmodule

// File: rtl/pmode_ctrl.sv
module pmode_ctrl
   import pmode_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter logic [7:0]  RST_VAL     = 8'h04,
   parameter bit          DBG_RULE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              dbg_mode,
   output logic              wr_reject,
   output logic              stop_req_o,
   output logic              halt_req_o,
   output logic              halt_deep_o,
   output logic              lsosc_en_o,
   output logic              hsosc_en_o,
   output logic              clk_hs_o
);

   localparam int unsigned PAD_W   = DATA_W - MODE_BITS;
   localparam mode_t       RST_MODE = mode_t'(RST_VAL[MODE_BITS-1:0]);

   generate
      if (DATA_W < MODE_BITS) begin : g_bad_width
         $error("pmode_ctrl: DATA_W must be at least MODE_BITS");
      end
      if (RST_VAL[7:MODE_BITS] != '0) begin : g_bad_reset
         $error("pmode_ctrl: RST_VAL must keep reserved bits clear");
      end
   endgenerate

   mode_t                cand;
   mode_t                cur;
   logic                 wr_fire;
   logic                 wr_ok;
   logic [NUM_RULES-1:0] viol;

   assign wr_fire = bus_sel && bus_wr;
   assign cand    = mode_t'(bus_wdata[MODE_BITS-1:0]);

   generate
      if (PAD_W > 0) begin : g_wide
         logic unused_hi;
         assign unused_hi = ^bus_wdata[DATA_W-1:MODE_BITS];
         assign bus_rdata = bus_sel ? {{PAD_W{1'b0}}, cur} : '0;
      end else begin : g_exact
         assign bus_rdata = bus_sel ? cur : '0;
      end
   endgenerate

   pmode_legal #(.DBG_RULE_EN(DBG_RULE_EN)) legal_i (
      .cand     (cand),
      .dbg_mode (dbg_mode),
      .viol     (viol),
      .ok       (wr_ok)
   );

   pmode_reg #(.RST_MODE(RST_MODE)) reg_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_fire (wr_fire),
      .wr_ok   (wr_ok),
      .cand    (cand),
      .q       (cur),
      .reject  (wr_reject)
   );

   assign stop_req_o  = cur.stop;
   assign halt_req_o  = cur.halt;
   assign halt_deep_o = cur.halt_deep;
   assign lsosc_en_o  = cur.lsosc;
   assign hsosc_en_o  = cur.hsosc;
   assign clk_hs_o    = cur.clk_hs;

endmodule

// File: rtl/pmode_ctrl_chk.sv
module pmode_ctrl_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              dbg_mode,
   input logic              wr_reject,
   input logic              stop_req_o,
   input logic              halt_req_o,
   input logic              halt_deep_o,
   input logic              lsosc_en_o,
   input logic              hsosc_en_o,
   input logic              clk_hs_o
);

   logic [5:0] st;
   assign st = {stop_req_o, halt_req_o, halt_deep_o, lsosc_en_o, hsosc_en_o, clk_hs_o};

   AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[DATA_W-1:6] == '0);  // R3

   AST_HS_HAS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
      (!halt_req_o && clk_hs_o) |-> hsosc_en_o);  // R5

   AST_LS_HAS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_hs_o |-> lsosc_en_o);  // R6

   AST_STOP_HALT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(stop_req_o && halt_req_o));  // R7

   AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_reject |-> $stable(st));  // R9

   AST_REJECT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_reject |-> $past(bus_sel && bus_wr));  // R9

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(bus_sel && bus_wr) && !wr_reject) |-> (st == $past(bus_wdata[5:0])));  // R4

   AST_NO_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_sel |=> $stable(st));  // R4

endmodule

bind pmode_ctrl pmode_ctrl_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/pmode_ctrl_tb_top.sv
`timescale 1ns/1ps
module pmode_ctrl_tb_top;

   localparam int unsigned NVEC = 13;
   // Entry: {dbg_mode, write data, expected accept}
   localparam logic [9:0] VEC [NVEC] = '{
      {1'b0, 8'h06, 1'b1},   // R2 enable high-speed oscillator
      {1'b0, 8'h07, 1'b1},   // R2 switch to high-speed clock
      {1'b0, 8'h05, 1'b0},   // R5 hs clock, hs osc off, no halt
      {1'b0, 8'h15, 1'b1},   // R5 same but halting: allowed
      {1'b0, 8'h34, 1'b0},   // R7 stop and halt together
      {1'b0, 8'h26, 1'b1},   // R2 stop request alone
      {1'b0, 8'h03, 1'b0},   // R8 ls osc off outside debug
      {1'b1, 8'h03, 1'b1},   // R8 same value in debug: allowed
      {1'b1, 8'h02, 1'b0},   // R6 ls clock without ls osc
      {1'b0, 8'hC6, 1'b1},   // R3 reserved bits set, read back clear
      {1'b0, 8'h1C, 1'b1},   // R2 deep halt on low-speed clock
      {1'b1, 8'h01, 1'b0},   // R5 hs clock, no oscillators, in debug
      {1'b0, 8'h04, 1'b1}    // R4 back to reset value
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       dbg_mode = 1'b0;
   logic       wr_reject;
   logic       stop_req_o, halt_req_o, halt_deep_o, lsosc_en_o, hsosc_en_o, clk_hs_o;

   int checks = 0;
   int errors = 0;
   logic [5:0] model;

   always #2.5 clk = ~clk;

   pmode_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dbg_mode(dbg_mode),
      .wr_reject(wr_reject), .stop_req_o(stop_req_o), .halt_req_o(halt_req_o),
      .halt_deep_o(halt_deep_o), .lsosc_en_o(lsosc_en_o), .hsosc_en_o(hsosc_en_o),
      .clk_hs_o(clk_hs_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Read with selection, compare read data, outputs and reject pulse
   task automatic check_state(input string req, input logic exp_rej);
      bus_sel = 1'b1;
      bus_wr  = 1'b0;
      #0.5;
      chk(req, {24'h0, bus_rdata}, {26'h0, model});
      chk(req, {26'h0, stop_req_o, halt_req_o, halt_deep_o, lsosc_en_o, hsosc_en_o, clk_hs_o},
          {26'h0, model});
      chk(req, {31'h0, wr_reject}, {31'h0, exp_rej});
   endtask

   task automatic do_write(input logic sel, input logic dbg, input logic [7:0] d);
      @(negedge clk);
      bus_sel   = sel;
      bus_wr    = 1'b1;
      dbg_mode  = dbg;
      bus_wdata = d;
      @(negedge clk);
      bus_wr    = 1'b0;
      bus_sel   = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      model = 6'h04;
      repeat (3) @(negedge clk);
      check_state("R1 in reset", 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check_state("R1 after reset", 1'b0);

      // Vector table
      for (int i = 0; i < NVEC; i++) begin
         logic ok;
         ok = VEC[i][0];
         do_write(1'b1, VEC[i][9], VEC[i][8:1]);
         if (ok) model = VEC[i][6:1];
         check_state(ok ? "R4 accepted write" : "R9 refused write", !ok);
      end

      // R9 pulse lasts one cycle
      do_write(1'b1, 1'b0, 8'h30);
      check_state("R9 reject pulse", 1'b1);
      @(negedge clk);
      check_state("R9 pulse ends", 1'b0);

      // R4 unselected write ignored
      do_write(1'b0, 1'b0, 8'h07);
      check_state("R4 no select no write", 1'b0);

      // R3 unselected read gives zero
      @(negedge clk);
      bus_sel = 1'b0;
      #0.5;
      chk("R3 unselected read", {24'h0, bus_rdata}, 32'h0);

      // R10 repeated reads change nothing
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         check_state("R10 read no side effect", 1'b0);
      end

      // R1 reset after activity
      do_write(1'b1, 1'b0, 8'h1F);
      model = 6'h1F;
      check_state("R2 write before reset", 1'b0);
      rst_n = 1'b0;
      model = 6'h04;
      #0.5;
      check_state("R1 reset mid-run", 1'b0);
      @(negedge clk);
      rst_n = 1'b1;

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule